// File: doc/BRIEF.md
# Power Button Reset Sequencer

This block decides when the on-chip regulators are enabled and when the rest of the chip is held in reset. It takes five inputs: a push button, a flag from the core-voltage monitor, a timeout flag from a watchdog, an active-low external reset pin and a one-cycle software shutdown strobe. The button passes through a two-flop synchronizer. A hold timer then measures how many consecutive cycles the button has been high. The regulators latch on after a press of sufficient length and stay on after the button is released. Only the software shutdown strobe, or loss of the supply-present input, turns them off again.

Every reset source drives a stretched chip reset: the low core voltage, the watchdog, the external pin and a very long button hold. None of them touches the regulator enable. For each regulator the block keeps a voltage code, and any active chip reset reloads those codes to their defaults. Software may write the codes only while the regulators are on and the chip reset is released. The synchronized button level is available as an ordinary readable input.

The analog regulators, the monitor comparators and the watchdog counter are outside the block. All flags are assumed synchronous to `clk`. All durations are parameters in clock cycles.

Top module: `pwrseq_top`

## Requirements
- R1: Starting from the off state, `reg_en` rises exactly START_CYC+3 clock edges after `btn_in` goes high and stays high. A press that keeps `btn_in` high for at most START_CYC-1 edges never raises `reg_en`.
- R2: While `reg_en` is high, only `sw_shutdown` or loss of `supply_ok` clears it. Button release and all reset sources leave it high.
- R3: A button held continuously while powered asserts `chip_rst` exactly LONG_CYC+3 edges after `btn_in` rises. The reset holds until the button is released and is then stretched as in R5.
- R4: `ext_rst_n` low, `cvdd_low` high or `wdog_expire` high, sampled at a clock edge, asserts `chip_rst` after that edge.
- R5: `chip_rst` falls exactly RST_HOLD edges after the last edge at which any reset source, including the off state, was sampled active.
- R6: While `chip_rst` is high, every voltage code reloads to its default, 20 + 8*index. The field for regulator i is `vcode_out[i*VCODE_W +: VCODE_W]`.
- R7: A write (`vcode_we` high, `vcode_sel` < NUM_REG) updates the selected code at the next edge only when `reg_en` is high and `chip_rst` is low. Otherwise it has no effect, and a select of NUM_REG or higher is always ignored.
- R8: `sw_shutdown` sampled high while powered clears `reg_en` at that edge. `chip_rst` is high whenever `reg_en` is low.
- R9: `supply_ok` low immediately forces `reg_en` low, `chip_rst` high and all codes to default, without waiting for a clock edge.
- R10: `btn_level` follows `btn_in` with a latency of two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_ok | input | 1 | Supply present; low acts as asynchronous power-off |
| btn_in | input | 1 | Raw power button, high when pressed |
| cvdd_low | input | 1 | Core voltage below threshold |
| wdog_expire | input | 1 | Watchdog timeout flag |
| ext_rst_n | input | 1 | External reset, active low |
| sw_shutdown | input | 1 | Software shutdown strobe |
| vcode_we | input | 1 | Voltage code write enable |
| vcode_sel | input | SEL_W | Regulator index for the write |
| vcode_wdata | input | VCODE_W | Voltage code to write |
| reg_en | output | 1 | Regulator enable |
| chip_rst | output | 1 | Chip reset, active high |
| btn_level | output | 1 | Synchronized button level |
| vcode_out | output | NUM_REG*VCODE_W | Packed voltage codes |

## Verification
The bench probes the press-length boundary on both sides. A press one cycle too short must leave the device off, and an off-by-one timer would turn it on early or late. It measures the exact edge at which the reset stretch releases after each source, and the exact edge of the long-hold reset. A miscounted stretch would release the chip too soon or hold it too long. It attempts writes during reset, while off, and with an out-of-range select, so a design that gated writes incorrectly would corrupt a code that must stay at default. It checks that every reset source leaves the regulators on, which a design that routed resets into the power state would violate.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic {PS_OFF = 1'b0, PS_ON = 1'b1} pwr_state_e;

  // Default voltage code of regulator idx after any reset
  function automatic int unsigned default_vcode(input int unsigned idx);
    return 20 + 8 * idx;
  endfunction

  // Saturating increment of a hold counter
  function automatic int unsigned sat_inc(input int unsigned cnt, input int unsigned lim);
    return (cnt >= lim) ? lim : cnt + 1;
  endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrseq_hold_timer.sv
module pwrseq_hold_timer
  import pwrseq_pkg::*;
#(
  parameter int unsigned START_CYC = 12000,
  parameter int unsigned LONG_CYC  = 67200000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic btn_s,
  output logic start_ok,
  output logic long_hold
);
  localparam int CNT_W = $clog2(LONG_CYC + 1);

  logic [CNT_W-1:0] hold_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    hold_cnt <= '0;
    else if (btn_s) hold_cnt <= CNT_W'(sat_inc(int'(hold_cnt), LONG_CYC));
    else            hold_cnt <= '0;
  end

  assign start_ok  = (hold_cnt >= CNT_W'(START_CYC));
  assign long_hold = (hold_cnt >= CNT_W'(LONG_CYC));

  // R3: a long hold always implies a valid start press
  assert_long_implies_start_R3: assert property (@(posedge clk) disable iff (!arst_n)
    long_hold |-> start_ok);

  // R1: counter can only grow while the synchronized button is high
  assert_cnt_clears_R1: assert property (@(posedge clk) disable iff (!arst_n)
    !btn_s |=> !start_ok);
endmodule

// File: rtl/pwrseq_rst_stretch.sv
module pwrseq_rst_stretch #(
  parameter int unsigned RST_HOLD = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic src,
  output logic rst_out
);
  localparam int CW = $clog2(RST_HOLD + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)          remain <= CW'(RST_HOLD);
    else if (src)         remain <= CW'(RST_HOLD);
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign rst_out = (remain != 0);

  // R4: an active source is always followed by reset
  assert_src_resets_R4: assert property (@(posedge clk) disable iff (!arst_n)
    src |=> rst_out);

  // R5: reset cannot fall while a source was active in the previous cycle
  assert_no_early_release_R5: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_out) |-> !$past(src));
endmodule

// File: rtl/pwrseq_vcode_bank.sv
module pwrseq_vcode_bank
  import pwrseq_pkg::*;
#(
  parameter int NUM_REG = 3,
  parameter int VCODE_W = 6,
  parameter int SEL_W   = 2
) (
  input  logic                       clk,
  input  logic                       arst_n,
  input  logic                       reload,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           sel,
  input  logic [VCODE_W-1:0]         wdata,
  output logic [NUM_REG*VCODE_W-1:0] codes
);
  for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
    localparam logic [VCODE_W-1:0] DFLT = VCODE_W'(default_vcode(i));
    logic [VCODE_W-1:0] code_q;
    logic               hit;

    assign hit = wr_en && (sel == SEL_W'(i));

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)     code_q <= DFLT;
      else if (reload) code_q <= DFLT;
      else if (hit)    code_q <= wdata;
    end

    assign codes[i*VCODE_W +: VCODE_W] = code_q;

    // R6: a reset cycle leaves the default code behind
    assert_reload_default_R6: assert property (@(posedge clk) disable iff (!arst_n)
      reload |=> (codes[i*VCODE_W +: VCODE_W] == DFLT));
  end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int unsigned START_CYC = 12000,
  parameter int unsigned LONG_CYC  = 67200000,
  parameter int unsigned RST_HOLD  = 16,
  parameter int          NUM_REG   = 3,
  parameter int          VCODE_W   = 6,
  parameter int          SEL_W     = (NUM_REG > 1) ? $clog2(NUM_REG + 1) : 1
) (
  input  logic                       clk,
  input  logic                       supply_ok,
  input  logic                       btn_in,
  input  logic                       cvdd_low,
  input  logic                       wdog_expire,
  input  logic                       ext_rst_n,
  input  logic                       sw_shutdown,
  input  logic                       vcode_we,
  input  logic [SEL_W-1:0]           vcode_sel,
  input  logic [VCODE_W-1:0]         vcode_wdata,
  output logic                       reg_en,
  output logic                       chip_rst,
  output logic                       btn_level,
  output logic [NUM_REG*VCODE_W-1:0] vcode_out
);
  pwr_state_e state;
  logic btn_s, start_ok, long_hold;
  logic rst_src, stretch_rst, wr_acc;

  pwrseq_sync #(.STAGES(2)) u_sync (
    .clk(clk), .arst_n(supply_ok), .d(btn_in), .q(btn_s)
  );

  pwrseq_hold_timer #(.START_CYC(START_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk(clk), .arst_n(supply_ok), .btn_s(btn_s),
    .start_ok(start_ok), .long_hold(long_hold)
  );

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) state <= PS_OFF;
    else begin
      case (state)
        PS_OFF:  if (start_ok)    state <= PS_ON;
        PS_ON:   if (sw_shutdown) state <= PS_OFF;
        default: state <= PS_OFF;
      endcase
    end
  end

  assign rst_src = (state == PS_OFF) || !ext_rst_n || cvdd_low || wdog_expire || long_hold;

  pwrseq_rst_stretch #(.RST_HOLD(RST_HOLD)) u_stretch (
    .clk(clk), .arst_n(supply_ok), .src(rst_src), .rst_out(stretch_rst)
  );

  assign reg_en    = (state == PS_ON);
  assign chip_rst  = stretch_rst || (state == PS_OFF);
  assign btn_level = btn_s;
  assign wr_acc    = vcode_we && reg_en && !chip_rst && (int'(vcode_sel) < NUM_REG);

  pwrseq_vcode_bank #(.NUM_REG(NUM_REG), .VCODE_W(VCODE_W), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .arst_n(supply_ok), .reload(chip_rst), .wr_en(wr_acc),
    .sel(vcode_sel), .wdata(vcode_wdata), .codes(vcode_out)
  );

  // R1: without a completed press the regulators stay off
  assert_no_early_on_R1: assert property (@(posedge clk) disable iff (!supply_ok)
    (!reg_en && !start_ok) |=> !reg_en);

  // R2: once on, only the shutdown strobe clears the enable
  assert_stays_on_R2: assert property (@(posedge clk) disable iff (!supply_ok)
    (reg_en && !sw_shutdown) |=> reg_en);

  // R3: a long hold produces a chip reset
  assert_long_hold_reset_R3: assert property (@(posedge clk) disable iff (!supply_ok)
    long_hold |=> chip_rst);

  // R7: without an accepted write or a reset the codes do not move
  assert_codes_hold_R7: assert property (@(posedge clk) disable iff (!supply_ok)
    (!chip_rst && !wr_acc) |=> $stable(vcode_out));

  // R8: shutdown while powered turns the regulators off, and off implies reset
  assert_shutdown_off_R8: assert property (@(posedge clk) disable iff (!supply_ok)
    (reg_en && sw_shutdown) |=> !reg_en);
  assert_off_means_reset_R8: assert property (@(posedge clk) disable iff (!supply_ok)
    !reg_en |-> chip_rst);
endmodule

// File: tb/pwrseq_top_tb_top.sv
module pwrseq_top_tb_top;
  localparam int S  = 16;
  localparam int L  = 200;
  localparam int H  = 5;
  localparam int NR = 3;
  localparam int VW = 6;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic supply_ok, btn_in, cvdd_low, wdog_expire, ext_rst_n, sw_shutdown, vcode_we;
  logic [SW-1:0] vcode_sel;
  logic [VW-1:0] vcode_wdata;
  logic reg_en, chip_rst, btn_level;
  logic [NR*VW-1:0] vcode_out;

  int checks = 0;
  int fails  = 0;
  logic [VW-1:0] model [NR];

  always #5 clk = ~clk;

  pwrseq_top #(.START_CYC(S), .LONG_CYC(L), .RST_HOLD(H), .NUM_REG(NR),
               .VCODE_W(VW), .SEL_W(SW)) dut_i (
    .clk(clk), .supply_ok(supply_ok), .btn_in(btn_in), .cvdd_low(cvdd_low),
    .wdog_expire(wdog_expire), .ext_rst_n(ext_rst_n), .sw_shutdown(sw_shutdown),
    .vcode_we(vcode_we), .vcode_sel(vcode_sel), .vcode_wdata(vcode_wdata),
    .reg_en(reg_en), .chip_rst(chip_rst), .btn_level(btn_level), .vcode_out(vcode_out)
  );

  function automatic logic [VW-1:0] dflt(input int i);
    return VW'((i << 3) + 20);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_defaults();
    for (int i = 0; i < NR; i++) model[i] = dflt(i);
  endtask

  task automatic check_codes(input string req);
    for (int i = 0; i < NR; i++)
      check(vcode_out[i*VW +: VW] == model[i], req, 32'(vcode_out[i*VW +: VW]), 32'(model[i]));
  endtask

  task automatic power_up();
    btn_in = 1'b1;
    step(S + 3);
    step(H + 1);
    btn_in = 1'b0;
    step(5);
  endtask

  task automatic do_write(input logic [SW-1:0] sel, input logic [VW-1:0] d, input logic accept);
    vcode_we = 1'b1; vcode_sel = sel; vcode_wdata = d;
    step(1);
    vcode_we = 1'b0;
    if (accept && int'(sel) < NR) model[sel] = d;
  endtask

  // which: 0 ext pin, 1 core voltage, 2 watchdog
  task automatic pulse_src(input int which, input int len, input string req);
    case (which)
      0: ext_rst_n = 1'b0;
      1: cvdd_low = 1'b1;
      default: wdog_expire = 1'b1;
    endcase
    step(1);
    check(chip_rst == 1'b1, req, 32'(chip_rst), 1);
    // write attempt during reset must not stick (R7)
    vcode_we = 1'b1; vcode_sel = 2'd1; vcode_wdata = 6'd63;
    step(1);
    vcode_we = 1'b0;
    step(len > 2 ? len - 2 : 0);
    ext_rst_n = 1'b1; cvdd_low = 1'b0; wdog_expire = 1'b0;
    model_defaults();
    check_codes("R6/R7 reset reload");
    check(reg_en == 1'b1, "R2 enable kept under reset", 32'(reg_en), 1);
    step(H - 1);
    check(chip_rst == 1'b1, "R5 stretch still held", 32'(chip_rst), 1);
    step(1);
    check(chip_rst == 1'b0, "R5 stretch release", 32'(chip_rst), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    supply_ok = 1'b0; btn_in = 1'b0; cvdd_low = 1'b0; wdog_expire = 1'b0;
    ext_rst_n = 1'b1; sw_shutdown = 1'b0; vcode_we = 1'b0;
    vcode_sel = '0; vcode_wdata = '0;
    model_defaults();
    step(3);
    check(reg_en == 1'b0, "R9 reset enable", 32'(reg_en), 0);
    check(chip_rst == 1'b1, "R9 reset chip_rst", 32'(chip_rst), 1);
    check_codes("R9 reset codes");
    supply_ok = 1'b1;
    step(2);

    // R10 latency
    btn_in = 1'b1;
    step(1);
    check(btn_level == 1'b0, "R10 one edge", 32'(btn_level), 0);
    step(1);
    check(btn_level == 1'b1, "R10 two edges", 32'(btn_level), 1);
    btn_in = 1'b0;
    step(6);
    check(reg_en == 1'b0, "R1 tiny press", 32'(reg_en), 0);

    // R1 short press boundary
    btn_in = 1'b1;
    step(S - 1);
    btn_in = 1'b0;
    step(10);
    check(reg_en == 1'b0, "R1 short press", 32'(reg_en), 0);

    // R1 full press timing, R5 power-on stretch
    btn_in = 1'b1;
    step(S + 2);
    check(reg_en == 1'b0, "R1 one before", 32'(reg_en), 0);
    step(1);
    check(reg_en == 1'b1, "R1 on edge", 32'(reg_en), 1);
    step(H - 1);
    check(chip_rst == 1'b1, "R5 power-on held", 32'(chip_rst), 1);
    step(1);
    check(chip_rst == 1'b0, "R5 power-on release", 32'(chip_rst), 0);
    btn_in = 1'b0;
    step(5);
    check(reg_en == 1'b1, "R2 after release", 32'(reg_en), 1);

    // R7 random writes, some out of range
    for (int k = 0; k < 24; k++) begin
      logic [SW-1:0] sel;
      logic [VW-1:0] d;
      sel = SW'($urandom % 4);
      d = VW'($urandom);
      do_write(sel, d, 1'b1);
      check_codes("R7 random write");
    end
    do_write(2'd3, 6'd5, 1'b1);
    check_codes("R7 out-of-range select");

    // R4/R5/R6 each reset source
    for (int src = 0; src < 3; src++) begin
      do_write(2'd0, 6'd1, 1'b1);
      do_write(2'd2, 6'd2, 1'b1);
      pulse_src(src, 1 + src * 2, "R4 source asserts reset");
    end

    // R3 long hold
    do_write(2'd1, 6'd9, 1'b1);
    btn_in = 1'b1;
    step(L + 2);
    check(chip_rst == 1'b0, "R3 before long hold", 32'(chip_rst), 0);
    step(1);
    check(chip_rst == 1'b1, "R3 long hold reset", 32'(chip_rst), 1);
    check(reg_en == 1'b1, "R2 long hold keeps enable", 32'(reg_en), 1);
    step(5);
    btn_in = 1'b0;
    step(H + 2);
    check(chip_rst == 1'b1, "R3 held until release", 32'(chip_rst), 1);
    step(1);
    check(chip_rst == 1'b0, "R3 release after stretch", 32'(chip_rst), 0);
    model_defaults();
    check_codes("R6 long hold reload");

    // R8 shutdown
    do_write(2'd2, 6'd44, 1'b1);
    sw_shutdown = 1'b1;
    step(1);
    sw_shutdown = 1'b0;
    check(reg_en == 1'b0, "R8 shutdown", 32'(reg_en), 0);
    check(chip_rst == 1'b1, "R8 off means reset", 32'(chip_rst), 1);
    step(1);
    model_defaults();
    check_codes("R6 shutdown reload");
    do_write(2'd0, 6'd33, 1'b0);
    check_codes("R7 write while off");
    step(4);
    check(reg_en == 1'b0, "R8 stays off", 32'(reg_en), 0);

    // R9 supply loss
    power_up();
    check(reg_en == 1'b1, "R1 repower", 32'(reg_en), 1);
    do_write(2'd1, 6'd50, 1'b1);
    check_codes("R7 write after repower");
    #2 supply_ok = 1'b0;
    #1;
    model_defaults();
    check(reg_en == 1'b0, "R9 async off", 32'(reg_en), 0);
    check(chip_rst == 1'b1, "R9 async reset", 32'(chip_rst), 1);
    check_codes("R9 async defaults");
    step(2);
    supply_ok = 1'b1;
    step(10);
    check(reg_en == 1'b0, "R9 stays off after return", 32'(reg_en), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule